// File: doc/BRIEF.md
# Flash status register sequencer

This block runs the command frames that a serial-flash controller needs to reach the flash's three status registers. A caller picks one of four operations with `opSel`: read a register, write a register, set the quad-enable bit, or poll until the flash is no longer busy. The block then drives chip select and a byte-shifter handshake. Each frame is a chip-select-low window that holds one or more shifted bytes. The write-protect and hold lines stay high throughout.

Two flag inputs change how writes are framed. `skipWel` drops the write-enable frame (0x06) that normally comes before the volatile-write-enable frame (0x50). `combineSr2` covers parts that have no separate register-2 write command: register 1 is read first, and its value is sent again ahead of the new register-2 value in a single 0x01 frame. The quad-enable operation reads register 2, sets bit 1 and writes the result back under the same rules. `rdValue` returns either the byte received or the byte written, and `done` pulses for one cycle at the end.

The byte shifter is outside this block. `shStart` pulses for one cycle with the byte on `shTx`. The shifter answers with a one-cycle `shDone` and the byte it received on `shRx`. A received byte is obtained by sending the dummy value 0xFF.

Top module: `flash_sr_sequencer`

## Requirements
- R1: Read (`opSel`=0) with `regSel` 1, 2 or 3 is one frame: opcode 0x05, 0x35 or 0x15 respectively, then dummy byte 0xFF. The byte received during the dummy is returned on `rdValue` with `done`.
- R2: Write (`opSel`=1) to register 1 or 3 uses three frames in this order: 0x06, 0x50, then 0x01 (register 1) or 0x11 (register 3) followed by `writeVal`. `rdValue` returns the value written.
- R3: With `skipWel`=1, every write sequence leaves out the 0x06 frame and keeps all other frames.
- R4: A register-2 write with `combineSr2`=0 ends with the frame 0x31 followed by the value.
- R5: A register-2 write with `combineSr2`=1 first reads register 1 (frame 0x05, 0xFF). After the enable frames, its final frame is 0x01, the received register-1 byte, then the register-2 value.
- R6: Quad enable (`opSel`=2) reads register 2 with 0x35, ORs in bit 1 (0x02), and writes the result to register 2 following R3 to R5. `rdValue` returns the written value.
- R7: Poll (`opSel`=3) repeats the register-1 read frame while bit 0 of the received byte is 1. It finishes after the first frame whose bit 0 is 0 and returns that byte.
- R8: `csN` is low only during frames, and `shStart` and `shDone` occur only while it is low. Between any two frames, `csN` stays high for at least `GAP_CYCLES` clock cycles.
- R9: `wpN` and `holdN` are high at all times.
- R10: Read or write with `regSel`=0 sends no frame. It raises `done` and `error` together within two cycles of the start. `error` is low on every other completion.
- R11: A `start` that arrives while `busy` is high is ignored. A `start` in the same cycle as `done` is accepted.
- R12: After reset, `csN` is high and `done`, `error`, `busy` and `shStart` are low. `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opSel | input | 2 | 0 read, 1 write, 2 quad enable, 3 busy poll |
| regSel | input | 2 | Status register number 1..3; 0 is invalid |
| writeVal | input | 8 | Value for a write operation |
| skipWel | input | 1 | Leave out the write-enable frame |
| combineSr2 | input | 1 | Write register 2 through a combined register-1/2 frame |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Set with done when the selector was invalid |
| rdValue | output | 8 | Received or written status byte |
| csN | output | 1 | Flash chip select, active low |
| wpN | output | 1 | Write-protect line, held high |
| holdN | output | 1 | Hold line, held high |
| shStart | output | 1 | Byte shifter start pulse |
| shTx | output | 8 | Byte to shift out |
| shDone | input | 1 | Byte shifter finished pulse |
| shRx | input | 8 | Byte shifted in |

## Verification
Two things can land in one cycle: the `done` pulse that closes one operation and the `start` that opens the next. The bench waits until it sees `done`, raises `start` in that same cycle, and expects the second operation's frames to follow after at least the chip-select gap. A `start` pulsed partway through a write is also checked: the frame scoreboard must receive no extra read frame, and exactly one result must come back.

// File: rtl/srseq_pkg.sv
package srseq_pkg;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_VWREN  = 8'h50;
  localparam logic [7:0] OPC_RD1    = 8'h05;
  localparam logic [7:0] OPC_RD2    = 8'h35;
  localparam logic [7:0] OPC_RD3    = 8'h15;
  localparam logic [7:0] OPC_WR1    = 8'h01;
  localparam logic [7:0] OPC_WR2    = 8'h31;
  localparam logic [7:0] OPC_WR3    = 8'h11;
  localparam logic [7:0] DUMMY_BYTE = 8'hFF;

  localparam int BUSY_BIT = 0;
  localparam int QE_BIT   = 1;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_QUAD_EN = 2'd2,
    OP_POLL    = 2'd3
  } seqOp_t;

  typedef enum logic [1:0] {
    FR_READ  = 2'd0,
    FR_WREN  = 2'd1,
    FR_VWREN = 2'd2,
    FR_WRITE = 2'd3
  } frameKind_t;

  typedef enum logic [1:0] {
    TX_OPC   = 2'd0,
    TX_DUMMY = 2'd1,
    TX_SR1   = 2'd2,
    TX_VAL   = 2'd3
  } txSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       latchVal;
    logic       csLow;
    logic       csHigh;
    logic       send;
    txSel_t     txSel;
    logic [7:0] opc;
    logic       capSr1;
    logic       capRmw;
    logic       capRd;
    logic       resultFromVal;
    logic       finOk;
    logic       finErr;
  } dpCtrl_t;

  function automatic logic [7:0] rdOpcode(input logic [1:0] r);
    case (r)
      2'd1:    rdOpcode = OPC_RD1;
      2'd2:    rdOpcode = OPC_RD2;
      2'd3:    rdOpcode = OPC_RD3;
      default: rdOpcode = DUMMY_BYTE;
    endcase
  endfunction

  function automatic logic [7:0] wrOpcode(input logic [1:0] r);
    case (r)
      2'd1:    wrOpcode = OPC_WR1;
      2'd2:    wrOpcode = OPC_WR2;
      2'd3:    wrOpcode = OPC_WR3;
      default: wrOpcode = DUMMY_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/srseq_control.sv
module srseq_control
  import srseq_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  input  logic [1:0] regSel,
  input  logic       skipWel,
  input  logic       combineSr2,
  input  logic       shDone,
  input  logic       rxBusyBit,
  output dpCtrl_t    ctrl,
  output logic       busy
);

  localparam int GCW = $clog2(GAP_CYCLES + 1);
  localparam logic [GCW-1:0] GAP_LAST = GCW'(GAP_CYCLES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SEND, S_WAIT, S_GAP, S_FIN, S_ERR
  } state_t;

  state_t     state;
  frameKind_t kind;
  seqOp_t     opQ;
  logic [1:0] byteIdx;
  logic [1:0] curReg;
  logic [1:0] regQ;
  logic       skipQ;
  logic       combQ;
  logic       rmwPend;
  logic       goFin;
  logic [GCW-1:0] gapCnt;

  // frame bookkeeping
  logic       combWr;
  logic [1:0] lastIdx;
  logic       frameEnd;
  logic       gapDone;
  frameKind_t writeEntry;
  frameKind_t nextKind;
  logic [1:0] nextCur;
  logic       nextRmw;
  logic       endFin;

  // start decode
  seqOp_t     opIn;
  logic       startSeen;
  logic       badSel;
  frameKind_t startKind;
  logic [1:0] startCur;
  logic [1:0] startReg;
  logic       startRmw;

  assign busy = (state != S_IDLE);

  always_comb begin
    opIn      = seqOp_t'(opSel);
    startSeen = start && (state == S_IDLE);
    badSel    = (regSel == 2'd0) && ((opIn == OP_READ) || (opIn == OP_WRITE));
    startKind = FR_READ;
    startCur  = 2'd1;
    startReg  = regSel;
    startRmw  = 1'b0;
    case (opIn)
      OP_READ:    startCur = regSel;
      OP_POLL:    startReg = 2'd1;
      OP_QUAD_EN: begin
        startCur = 2'd2;
        startReg = 2'd2;
        startRmw = 1'b1;
      end
      default: begin
        if (!((regSel == 2'd2) && combineSr2))
          startKind = skipWel ? FR_VWREN : FR_WREN;
      end
    endcase
  end

  always_comb begin
    combWr     = combQ && (regQ == 2'd2);
    writeEntry = skipQ ? FR_VWREN : FR_WREN;
    case (kind)
      FR_READ:  lastIdx = 2'd1;
      FR_WRITE: lastIdx = combWr ? 2'd2 : 2'd1;
      default:  lastIdx = 2'd0;
    endcase
    frameEnd = (state == S_WAIT) && shDone && (byteIdx == lastIdx);
    gapDone  = (gapCnt == GAP_LAST);

    endFin   = 1'b0;
    nextKind = kind;
    nextCur  = curReg;
    nextRmw  = rmwPend;
    case (kind)
      FR_READ: begin
        if (opQ == OP_READ) begin
          endFin = 1'b1;
        end else if (opQ == OP_POLL) begin
          endFin = !rxBusyBit;
        end else if (rmwPend && combWr) begin
          nextCur = 2'd1;
          nextRmw = 1'b0;
        end else begin
          nextKind = writeEntry;
          nextRmw  = 1'b0;
        end
      end
      FR_WREN:  nextKind = FR_VWREN;
      FR_VWREN: nextKind = FR_WRITE;
      default:  endFin   = 1'b1;
    endcase
  end

  // strobes
  always_comb begin
    ctrl = '0;
    case (kind)
      FR_READ: begin
        ctrl.opc   = rdOpcode(curReg);
        ctrl.txSel = (byteIdx == 2'd0) ? TX_OPC : TX_DUMMY;
      end
      FR_WREN:  ctrl.opc = OPC_WREN;
      FR_VWREN: ctrl.opc = OPC_VWREN;
      default: begin
        ctrl.opc = combWr ? OPC_WR1 : wrOpcode(regQ);
        if (byteIdx == 2'd0)      ctrl.txSel = TX_OPC;
        else if (byteIdx == 2'd1) ctrl.txSel = combWr ? TX_SR1 : TX_VAL;
        else                      ctrl.txSel = TX_VAL;
      end
    endcase
    ctrl.send     = (state == S_SEND);
    ctrl.latchVal = startSeen && !badSel;
    ctrl.csLow    = (startSeen && !badSel) ||
                    ((state == S_GAP) && gapDone && !goFin);
    ctrl.csHigh   = frameEnd;
    if (frameEnd && (kind == FR_READ)) begin
      if ((opQ == OP_READ) || (opQ == OP_POLL)) ctrl.capRd  = 1'b1;
      else if (rmwPend)                         ctrl.capRmw = 1'b1;
      else                                      ctrl.capSr1 = 1'b1;
    end
    ctrl.finOk         = (state == S_FIN);
    ctrl.finErr        = (state == S_ERR);
    ctrl.resultFromVal = (state == S_FIN) &&
                         ((opQ == OP_WRITE) || (opQ == OP_QUAD_EN));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      kind    <= FR_READ;
      opQ     <= OP_READ;
      byteIdx <= '0;
      curReg  <= 2'd1;
      regQ    <= 2'd1;
      skipQ   <= 1'b0;
      combQ   <= 1'b0;
      rmwPend <= 1'b0;
      goFin   <= 1'b0;
      gapCnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (startSeen) begin
            if (badSel) begin
              state <= S_ERR;
            end else begin
              state   <= S_SEND;
              opQ     <= opIn;
              kind    <= startKind;
              curReg  <= startCur;
              regQ    <= startReg;
              rmwPend <= startRmw;
              skipQ   <= skipWel;
              combQ   <= combineSr2;
              byteIdx <= '0;
            end
          end
        end
        S_SEND: state <= S_WAIT;
        S_WAIT: begin
          if (shDone) begin
            if (byteIdx == lastIdx) begin
              state   <= S_GAP;
              gapCnt  <= '0;
              goFin   <= endFin;
              kind    <= nextKind;
              curReg  <= nextCur;
              rmwPend <= nextRmw;
              byteIdx <= '0;
            end else begin
              byteIdx <= byteIdx + 2'd1;
              state   <= S_SEND;
            end
          end
        end
        S_GAP: begin
          if (gapDone) state <= goFin ? S_FIN : S_SEND;
          else         gapCnt <= gapCnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: a start while busy leaves the captured operation untouched
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(opQ) && $stable(regQ)));

  // R10: an error completion never issues a byte
  assert_err_no_send_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ERR) |-> !ctrl.send);

endmodule

// File: rtl/srseq_datapath.sv
module srseq_datapath
  import srseq_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic [7:0] writeVal,
  input  logic       shDone,
  input  logic [7:0] shRx,
  output logic       rxBusyBit,
  output logic       csN,
  output logic       wpN,
  output logic       holdN,
  output logic       shStart,
  output logic [7:0] shTx,
  output logic [7:0] rdValue,
  output logic       done,
  output logic       error
);

  localparam int GCW = $clog2(GAP_CYCLES + 1);
  localparam logic [GCW-1:0] GAP_SAT = GCW'(GAP_CYCLES);
  localparam logic [7:0] QE_MASK = 8'(1 << QE_BIT);

  logic [7:0] valReg;
  logic [7:0] sr1Reg;
  logic [7:0] txByte;
  logic [GCW-1:0] highRun;

  assign wpN       = 1'b1;
  assign holdN     = 1'b1;
  assign rxBusyBit = shRx[BUSY_BIT];

  always_comb begin
    case (ctrl.txSel)
      TX_OPC:   txByte = ctrl.opc;
      TX_DUMMY: txByte = DUMMY_BYTE;
      TX_SR1:   txByte = sr1Reg;
      default:  txByte = valReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valReg  <= '0;
      sr1Reg  <= '0;
      rdValue <= '0;
      csN     <= 1'b1;
      shStart <= 1'b0;
      shTx    <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      highRun <= GAP_SAT;
    end else begin
      if (ctrl.latchVal)    valReg <= writeVal;
      else if (ctrl.capRmw) valReg <= shRx | QE_MASK;
      if (ctrl.capSr1)      sr1Reg <= shRx;
      if (ctrl.capRd)              rdValue <= shRx;
      else if (ctrl.resultFromVal) rdValue <= valReg;
      if (ctrl.csLow)       csN <= 1'b0;
      else if (ctrl.csHigh) csN <= 1'b1;
      shStart <= ctrl.send;
      if (ctrl.send) shTx <= txByte;
      done  <= ctrl.finOk | ctrl.finErr;
      error <= ctrl.finErr;
      if (!csN)                  highRun <= '0;
      else if (highRun != GAP_SAT) highRun <= highRun + 1'b1;
    end
  end

  // R8: chip select stays high long enough between frames
  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highRun == GAP_SAT));

  // R8: shifter activity only inside a frame
  assert_shift_in_frame_R8: assert property (@(posedge clk) disable iff (!rstN)
    (shStart || shDone) |-> !csN);

  // R10: error is only ever reported with done
  assert_error_with_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R12: done is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/flash_sr_sequencer.sv
module flash_sr_sequencer
  import srseq_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  input  logic [1:0] regSel,
  input  logic [7:0] writeVal,
  input  logic       skipWel,
  input  logic       combineSr2,
  output logic       busy,
  output logic       done,
  output logic       error,
  output logic [7:0] rdValue,
  output logic       csN,
  output logic       wpN,
  output logic       holdN,
  output logic       shStart,
  output logic [7:0] shTx,
  input  logic       shDone,
  input  logic [7:0] shRx
);

  dpCtrl_t ctrl;
  logic    rxBusyBit;

  srseq_control #(.GAP_CYCLES(GAP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .regSel(regSel),
    .skipWel(skipWel), .combineSr2(combineSr2), .shDone(shDone),
    .rxBusyBit(rxBusyBit), .ctrl(ctrl), .busy(busy)
  );

  srseq_datapath #(.GAP_CYCLES(GAP_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .writeVal(writeVal),
    .shDone(shDone), .shRx(shRx), .rxBusyBit(rxBusyBit), .csN(csN),
    .wpN(wpN), .holdN(holdN), .shStart(shStart), .shTx(shTx),
    .rdValue(rdValue), .done(done), .error(error)
  );

  // R8: no frame is open while the block is idle
  assert_idle_cs_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

endmodule

// File: tb/sim_flash_sr_sequencer.sv
module sim_flash_sr_sequencer;

  localparam int GAP    = 4;
  localparam int SH_LAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [1:0] opSel = 2'd0;
  logic [1:0] regSel = 2'd1;
  logic [7:0] writeVal = 8'h00;
  logic       skipWel = 1'b0;
  logic       combineSr2 = 1'b0;
  logic       busy, done, error, csN, wpN, holdN, shStart;
  logic [7:0] rdValue, shTx;
  logic       shDone = 1'b0;
  logic [7:0] shRx = 8'hFF;

  flash_sr_sequencer #(.GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .regSel(regSel),
    .writeVal(writeVal), .skipWel(skipWel), .combineSr2(combineSr2),
    .busy(busy), .done(done), .error(error), .rdValue(rdValue), .csN(csN),
    .wpN(wpN), .holdN(holdN), .shStart(shStart), .shTx(shTx),
    .shDone(shDone), .shRx(shRx)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // flash model (written only by monitor)
  logic [7:0] m1 = 8'h5C, m2 = 8'h00, m3 = 8'h60;
  int readsSeen = 0;
  // driver-owned
  int busyTarget = 0;
  logic [7:0] s1 = 8'h5C, s2 = 8'h00, s3 = 8'h60;

  logic [31:0] expFrames[$];
  logic [9:0]  expRes[$];   // {careVal, err, value}

  function automatic logic [31:0] fw(input int len, input logic [7:0] b0, b1, b2);
    return {8'(len), b0, b1, b2};
  endfunction

  // shifter, frame monitor and result monitor
  logic [7:0] fb0 = 0, fb1 = 0, fb2 = 0;
  int fn = 0, shCnt = 0, highCnt = 1000;
  logic [7:0] pendRx = 8'hFF;
  logic prevCs = 1'b1;

  always @(negedge clk) begin
    if (shDone) shDone = 1'b0;
    if (shCnt != 0) begin
      shCnt--;
      if (shCnt == 0) begin shDone = 1'b1; shRx = pendRx; end
    end
    if (shStart) begin
      if (fn == 0) fb0 = shTx; else if (fn == 1) fb1 = shTx; else if (fn == 2) fb2 = shTx;
      pendRx = 8'hFF;
      if (fn == 1) begin
        case (fb0)
          8'h05: pendRx = {m1[7:1], (readsSeen < busyTarget)};
          8'h35: pendRx = m2;
          8'h15: pendRx = m3;
          default: pendRx = 8'hFF;
        endcase
      end
      fn++;
      shCnt = SH_LAT;
    end
    if (prevCs && !csN) begin
      chk(highCnt >= GAP, "R8 chip-select gap", highCnt, GAP);
      chk(wpN && holdN, "R9 wp/hold high in frame", {wpN, holdN}, 2'b11);
    end
    if (!prevCs && csN) begin
      if (expFrames.size() == 0) chk(0, "R11 unexpected frame", fw(fn, fb0, fb1, fb2), 0);
      else begin
        logic [31:0] e;
        e = expFrames.pop_front();
        chk(fw(fn, fb0, fb1, fb2) == e, "R1-R7 frame content", fw(fn, fb0, fb1, fb2), e);
      end
      case (fb0)
        8'h01: begin m1 = fb1; if (fn == 3) m2 = fb2; end
        8'h31: m2 = fb1;
        8'h11: m3 = fb1;
        8'h05: readsSeen++;
        default: ;
      endcase
      fn = 0; fb0 = 0; fb1 = 0; fb2 = 0;
      highCnt = 1;
    end else if (csN && highCnt < 1000) highCnt++;
    prevCs = csN;
    if (done) begin
      if (expRes.size() == 0) chk(0, "R11 unexpected done", {error, rdValue}, 0);
      else begin
        logic [9:0] r;
        r = expRes.pop_front();
        chk(error == r[8], "R10 error flag", error, r[8]);
        if (r[9]) chk(rdValue == r[7:0], "R1/R2/R6/R7 rdValue", rdValue, r[7:0]);
      end
    end
  end

  task automatic expectWrite(input logic [1:0] r, input logic [7:0] v, input bit skip, input bit comb);
    logic [7:0] rep;
    if (r == 2'd2 && comb) begin
      rep = {s1[7:1], 1'b0};
      expFrames.push_back(fw(2, 8'h05, 8'hFF, 0));               // R5
      if (!skip) expFrames.push_back(fw(1, 8'h06, 0, 0));         // R3
      expFrames.push_back(fw(1, 8'h50, 0, 0));
      expFrames.push_back(fw(3, 8'h01, rep, v));                  // R5
      s1 = rep; s2 = v;
    end else begin
      if (!skip) expFrames.push_back(fw(1, 8'h06, 0, 0));         // R2 R3
      expFrames.push_back(fw(1, 8'h50, 0, 0));
      case (r)
        2'd1: begin expFrames.push_back(fw(2, 8'h01, v, 0)); s1 = v; end
        2'd2: begin expFrames.push_back(fw(2, 8'h31, v, 0)); s2 = v; end // R4
        default: begin expFrames.push_back(fw(2, 8'h11, v, 0)); s3 = v; end
      endcase
    end
    expRes.push_back({2'b10, v});
  endtask

  task automatic runOp(input logic [1:0] op, input logic [1:0] rs, input logic [7:0] v,
                       input bit skip, input bit comb, input int busyN,
                       input bit sneak, input bit chain);
    logic [7:0] q;
    int n;
    case (op)
      2'd0: begin
        if (rs == 0) expRes.push_back(10'b01_0000_0000);
        else begin
          expFrames.push_back(fw(2, (rs == 1) ? 8'h05 : (rs == 2) ? 8'h35 : 8'h15, 8'hFF, 0)); // R1
          q = (rs == 1) ? {s1[7:1], 1'b0} : (rs == 2) ? s2 : s3;
          expRes.push_back({2'b10, q});
        end
      end
      2'd1: begin
        if (rs == 0) expRes.push_back(10'b01_0000_0000);
        else expectWrite(rs, v, skip, comb);
      end
      2'd2: begin
        expFrames.push_back(fw(2, 8'h35, 8'hFF, 0));                // R6
        expectWrite(2'd2, s2 | 8'h02, skip, comb);
      end
      default: begin
        busyTarget = readsSeen + busyN;
        for (int i = 0; i <= busyN; i++) expFrames.push_back(fw(2, 8'h05, 8'hFF, 0)); // R7
        expRes.push_back({2'b10, s1[7:1], 1'b0});
      end
    endcase
    opSel = op; regSel = rs; writeVal = v; skipWel = skip; combineSr2 = comb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (sneak) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R11 busy during operation", busy, 1);
      opSel = 2'd0; regSel = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if ((op == 2'd0 || op == 2'd1) && rs == 0)
      chk(n <= 2, "R10 error completion latency", n, 2);
    if (!chain) repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        chk(csN == 1'b1, "R12 reset csN", csN, 1);
        chk(done == 1'b0 && error == 1'b0, "R12 reset done/error", {done, error}, 0);
        chk(busy == 1'b0 && shStart == 1'b0, "R12 reset busy/shStart", {busy, shStart}, 0);
        chk(wpN && holdN, "R9 wp/hold high after reset", {wpN, holdN}, 2'b11);
        // R1 reads of each register
        runOp(2'd0, 2'd1, 0, 0, 0, 0, 0, 0);
        runOp(2'd0, 2'd2, 0, 0, 0, 0, 0, 0);
        runOp(2'd0, 2'd3, 0, 0, 0, 0, 0, 0);
        // R2 full write framing, registers 1 and 3
        runOp(2'd1, 2'd1, 8'hA4, 0, 0, 0, 0, 0);
        runOp(2'd1, 2'd3, 8'h3C, 0, 0, 0, 0, 0);
        runOp(2'd0, 2'd3, 0, 0, 0, 0, 0, 0);
        // R3 skip write-enable
        runOp(2'd1, 2'd1, 8'h72, 1, 0, 0, 0, 0);
        // R4 separate register-2 write
        runOp(2'd1, 2'd2, 8'h40, 0, 0, 0, 0, 0);
        // R5 combined register-2 write
        runOp(2'd1, 2'd2, 8'h81, 1, 1, 0, 0, 0);
        runOp(2'd0, 2'd2, 0, 0, 0, 0, 0, 0);
        // R6 quad enable, both framings
        runOp(2'd2, 2'd0, 0, 0, 0, 0, 0, 0);
        runOp(2'd1, 2'd2, 8'h10, 0, 0, 0, 0, 0);
        runOp(2'd2, 2'd0, 0, 0, 1, 0, 0, 0);
        // R7 poll, idle and busy
        runOp(2'd3, 2'd0, 0, 0, 0, 0, 0, 0);
        runOp(2'd3, 2'd0, 0, 0, 0, 3, 0, 0);
        // R10 invalid selector
        runOp(2'd0, 2'd0, 0, 0, 0, 0, 0, 0);
        runOp(2'd1, 2'd0, 8'h55, 0, 0, 0, 0, 0);
        // R11 start while busy is ignored
        runOp(2'd1, 2'd3, 8'h9E, 0, 0, 0, 1, 0);
        // R11 start in the done cycle is accepted
        runOp(2'd1, 2'd1, 8'hC6, 1, 0, 0, 0, 1);
        chk(done == 1'b1, "R11 next start lands in done cycle", done, 1);
        runOp(2'd0, 2'd1, 0, 0, 0, 0, 0, 0);
        repeat (10) @(negedge clk);
        chk(expFrames.size() == 0, "R1-R7 all expected frames seen", expFrames.size(), 0);
        chk(expRes.size() == 0, "R12 all expected completions seen", expRes.size(), 0);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R12 actual=hung expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule